// File: doc/BRIEF.md
# MIDI Serial Port with Transmit and Receive Queues

This block connects a host's byte-wide register bus to a pair of MIDI serial lines. The host sees two registers selected by a one-bit address. Address 0 is the data register: writes go to the transmitter and reads take the oldest received byte. Address 1 is the status register, which is read-only. Outgoing bytes pass through a queue into a shifter that drives the serial output. Incoming frames are recovered by an oversampling receiver and stored in a second queue. An interrupt line tells the host that received bytes are waiting.

Two inputs shape how the transmit side behaves. The first picks what happens when the transmit queue is full. In overwrite mode the newest queued byte is replaced and the host never sees a busy flag. In stall mode the busy flag rises and further writes are dropped. The second input is a hold line. While it is high, the transmitter launches no new frame and output buffering shrinks to a single byte that later writes can overwrite. That byte goes out automatically once the hold line falls.

The line rate comes from the `CLK_DIV` parameter, which gives the number of clocks per bit (31250 baud at the default 50 MHz clock). Queue depth is set by `DEPTH` and is 16 by default. The receiver oversampling factor is set by `OVS`.

Top module: `midi_uart_port`

## Requirements
- R1: After reset, `tx_line` is 1 and `irq` is 0, and a status read returns 8'h80. The status register is laid out as follows: bit 7 is 1 when the receive queue is empty, bit 6 is 1 when the host must not write, bit 0 is the sticky overrun flag, and all other bits read 0.
- R2: Each transmitted byte is a 10-bit frame: a start bit of 0, then 8 data bits with the least significant bit first, then a stop bit of 1. Every bit lasts `CLK_DIV` clocks, and the line rests at 1 between frames.
- R3: When the transmitter is idle and its queue is empty, a data write starts a frame straight away. The following `DEPTH` writes are queued and sent in the order they were written.
- R4: With `overwrite_mode` = 1, a data write to a full transmit queue replaces the most recently queued byte, and status bit 6 stays 0.
- R5: With `overwrite_mode` = 0, status bit 6 reads 1 while the transmit queue is full, and data writes made in that state are dropped. Bit 6 returns to 0 once a byte moves from the queue into the shifter.
- R6: While `hold` = 1, no new frame starts. The first data write is kept without being sent and sets status bit 6. Later writes replace that kept byte.
- R7: When `hold` falls, the kept byte is transmitted automatically and status bit 6 returns to 0.
- R8: A received frame is sampled at mid-bit, with the least significant bit first. Each byte is stored in the receive queue. A data-register read returns bytes in arrival order and pops them. Status bit 7 reads 0 while a byte is waiting.
- R9: `irq` rises within two clocks of a byte entering the receive queue, and it is 0 whenever the receive queue is empty.
- R10: A byte that completes while the receive queue already holds `DEPTH` bytes is dropped and sets status bit 0. The bytes already stored stay intact. Bit 0 stays set until a status read, which clears it.
- R11: A low pulse shorter than half a bit period does not produce a byte. A frame whose stop bit is 0 is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 1 | Register select: 0 data, 1 status |
| wr_en | input | 1 | Write strobe, one clock per access |
| rd_en | input | 1 | Read strobe, one clock per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, valid the clock after `rd_en` |
| overwrite_mode | input | 1 | 1: replace newest byte when full, 0: stall with busy flag |
| hold | input | 1 | Freezes the transmitter and enables single-byte holding |
| tx_line | output | 1 | Serial MIDI output |
| rx_line | input | 1 | Serial MIDI input (asynchronous) |
| irq | output | 1 | High while received data waits |

## Verification
The bench builds the port with `CLK_DIV` = 32, `OVS` = 16 and `DEPTH` = 4. At these values a whole frame takes 320 clocks and a queue fills after four writes. This makes the full-queue, overwrite, drop and overrun cases cheap to reach. The same small setup lets the bench send every one of the 256 byte values through the receiver and check each one. A line monitor in the bench decodes the transmitted frames, so the overwrite and stall orderings can be compared against sequences computed from `DEPTH`.

// File: rtl/midi_uart_pkg.sv
package midi_uart_pkg;
  localparam int STAT_DSR_BIT = 7;
  localparam int STAT_DRR_BIT = 6;
  localparam int STAT_OVR_BIT = 0;
  localparam int FRAME_BITS   = 10;
  localparam logic REG_DATA   = 1'b0;
  localparam logic REG_STATUS = 1'b1;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_t;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic         replace,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr, wprev;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_pop  = pop & ~empty;
  assign do_push = push & (~full | do_pop);
  assign wprev   = (wptr == '0) ? LAST : wptr - AW'(1);
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push)
      mem[wptr] <= din;
    else if (replace && !empty)
      mem[wprev] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + AW'(1);
      if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/midi_tx.sv
module midi_tx
  import midi_uart_pkg::*;
#(
  parameter int CLK_DIV = 1600
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] din,
  output logic       ready,
  output logic       line
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int IW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sh;
  logic [IW-1:0]         idx;
  logic [DW-1:0]         div;
  logic                  busy;

  assign ready = ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      idx  <= '0;
      div  <= '0;
      busy <= 1'b0;
      line <= 1'b1;
    end else if (!busy) begin
      if (load) begin
        sh   <= {1'b1, din, 1'b0};
        line <= 1'b0;
        idx  <= '0;
        div  <= '0;
        busy <= 1'b1;
      end
    end else if (div == DW'(CLK_DIV - 1)) begin
      div <= '0;
      if (idx == IW'(FRAME_BITS - 1)) begin
        busy <= 1'b0;
        line <= 1'b1;
      end else begin
        idx  <= idx + IW'(1);
        sh   <= {1'b1, sh[FRAME_BITS-1:1]};
        line <= sh[1];
      end
    end else begin
      div <= div + DW'(1);
    end
  end
endmodule

// File: rtl/midi_rx.sv
module midi_rx
  import midi_uart_pkg::*;
#(
  parameter int CLK_DIV = 1600,
  parameter int OVS     = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_in,
  output logic       byte_valid,
  output logic [7:0] byte_out
);
  localparam int TICK_DIV = CLK_DIV / OVS;
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int OW = (OVS > 1) ? $clog2(OVS) : 1;

  logic [1:0]    sync;
  logic          rxd, last, tick;
  logic [TW-1:0] tcnt;
  logic [OW-1:0] ocnt;
  logic [2:0]    bidx;
  rx_state_t     state;

  assign rxd  = sync[1];
  assign tick = (tcnt == TW'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sync <= 2'b11;
      tcnt <= '0;
    end else begin
      sync <= {sync[0], line_in};
      tcnt <= tick ? '0 : tcnt + TW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= RX_IDLE;
      last       <= 1'b1;
      ocnt       <= '0;
      bidx       <= '0;
      byte_out   <= '0;
      byte_valid <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      if (tick) begin
        last <= rxd;
        case (state)
          RX_IDLE: begin
            if (last && !rxd) begin
              state <= RX_START;
              ocnt  <= '0;
            end
          end
          RX_START: begin
            if (ocnt == OW'(OVS / 2 - 1)) begin
              ocnt  <= '0;
              bidx  <= '0;
              state <= rxd ? RX_IDLE : RX_DATA;
            end else begin
              ocnt <= ocnt + OW'(1);
            end
          end
          RX_DATA: begin
            if (ocnt == OW'(OVS - 1)) begin
              ocnt     <= '0;
              byte_out <= {rxd, byte_out[7:1]};
              if (bidx == 3'd7) state <= RX_STOP;
              else bidx <= bidx + 3'd1;
            end else begin
              ocnt <= ocnt + OW'(1);
            end
          end
          RX_STOP: begin
            if (ocnt == OW'(OVS - 1)) begin
              ocnt       <= '0;
              byte_valid <= rxd;
              state      <= RX_IDLE;
            end else begin
              ocnt <= ocnt + OW'(1);
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/midi_uart_port.sv
module midi_uart_port
  import midi_uart_pkg::*;
#(
  parameter int CLK_DIV = 1600,
  parameter int OVS     = 16,
  parameter int DEPTH   = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       overwrite_mode,
  input  logic       hold,
  output logic       tx_line,
  input  logic       rx_line,
  output logic       irq
);
  // host decode
  logic wr_data, rd_data, rd_stat;
  assign wr_data = wr_en & (addr == REG_DATA);
  assign rd_data = rd_en & (addr == REG_DATA);
  assign rd_stat = rd_en & (addr == REG_STATUS);

  // hold register
  logic       hold_valid, hold_path, release_go;
  logic [7:0] hold_byte;
  assign hold_path = hold | hold_valid;

  // transmit path
  logic       tx_empty, tx_full, tx_ready, tx_pop, tx_push, tx_replace, tx_load;
  logic       host_src, src_valid, direct;
  logic [7:0] src_byte, tx_head, tx_ld_byte;
  logic       drr;

  assign host_src   = wr_data & ~hold_path;
  assign release_go = ~hold & hold_valid & ~wr_data & ~tx_full;
  assign src_valid  = host_src | release_go;
  assign src_byte   = release_go ? hold_byte : wdata;
  assign direct     = src_valid & tx_empty & tx_ready;
  assign tx_pop     = tx_ready & ~tx_empty & ~hold;
  assign tx_push    = src_valid & ~direct & (~tx_full | tx_pop);
  assign tx_replace = host_src & tx_full & ~tx_pop & overwrite_mode;
  assign tx_load    = direct | tx_pop;
  assign tx_ld_byte = direct ? src_byte : tx_head;
  assign drr        = hold_valid | (~overwrite_mode & tx_full);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_valid <= 1'b0;
      hold_byte  <= '0;
    end else if (wr_data && hold_path) begin
      hold_valid <= 1'b1;
      hold_byte  <= wdata;
    end else if (release_go) begin
      hold_valid <= 1'b0;
    end
  end

  byte_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(tx_push), .pop(tx_pop), .replace(tx_replace),
    .din(src_byte), .dout(tx_head), .empty(tx_empty), .full(tx_full)
  );

  midi_tx #(.CLK_DIV(CLK_DIV)) u_tx (
    .clk(clk), .rst(rst), .load(tx_load), .din(tx_ld_byte),
    .ready(tx_ready), .line(tx_line)
  );

  // receive path
  logic       rx_valid, rx_push, rx_pop, rx_empty, rx_full, ovr;
  logic [7:0] rx_byte, rx_head;

  assign rx_push = rx_valid & ~rx_full;
  assign rx_pop  = rd_data & ~rx_empty;

  midi_rx #(.CLK_DIV(CLK_DIV), .OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .line_in(rx_line),
    .byte_valid(rx_valid), .byte_out(rx_byte)
  );

  byte_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .pop(rx_pop), .replace(1'b0),
    .din(rx_byte), .dout(rx_head), .empty(rx_empty), .full(rx_full)
  );

  // status and read data
  logic [7:0] status_word;
  always_comb begin
    status_word               = '0;
    status_word[STAT_DSR_BIT] = rx_empty;
    status_word[STAT_DRR_BIT] = drr;
    status_word[STAT_OVR_BIT] = ovr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr   <= 1'b0;
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= ~rx_empty;
      if (rx_valid && rx_full) ovr <= 1'b1;
      else if (rd_stat)        ovr <= 1'b0;
      if (rd_stat)      rdata <= status_word;
      else if (rd_data) rdata <= rx_empty ? 8'h00 : rx_head;
    end
  end
endmodule

// File: rtl/midi_uart_chk.sv
module midi_uart_chk (
  input logic clk,
  input logic rst,
  input logic hold,
  input logic overwrite_mode,
  input logic wr_data,
  input logic hold_path,
  input logic tx_full,
  input logic tx_pop,
  input logic tx_ready,
  input logic tx_line,
  input logic rx_push,
  input logic rx_empty,
  input logic rx_valid,
  input logic rx_full,
  input logic ovr,
  input logic irq,
  input logic drr
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> tx_line); // R2
  AST_STALL_KEEPS_FULL: assert property (@(posedge clk) disable iff (rst)
    (wr_data && !overwrite_mode && tx_full && !tx_pop && !hold_path) |=> tx_full); // R5
  AST_HOLD_NO_FRAME: assert property (@(posedge clk) disable iff (rst)
    (hold && tx_ready) |=> tx_ready); // R6
  AST_HOLD_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (wr_data && hold) |=> drr); // R6
  AST_IRQ_AFTER_PUSH: assert property (@(posedge clk) disable iff (rst)
    rx_push |=> ##1 irq); // R9
  AST_IRQ_LOW_EMPTY: assert property (@(posedge clk) disable iff (rst)
    rx_empty |=> !irq); // R9
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_full) |=> ovr); // R10
endmodule

bind midi_uart_port midi_uart_chk u_chk (.*);

// File: tb/sim_midi_uart_port.sv
`timescale 1ns/1ps
module sim_midi_uart_port;
  localparam int CLK_DIV = 32;
  localparam int OVS     = 16;
  localparam int DEPTH   = 4;
  localparam int FRAME   = 10 * CLK_DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       overwrite_mode = 1'b0, hold = 1'b0;
  logic       tx_line, irq;
  logic       rx_drv = 1'b1;

  always #2.5 clk = ~clk;

  midi_uart_port #(.CLK_DIV(CLK_DIV), .OVS(OVS), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .overwrite_mode(overwrite_mode),
    .hold(hold), .tx_line(tx_line), .rx_line(rx_drv), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // line monitor: decodes frames from tx_line
  logic [7:0] mon_q [0:1023];
  int mon_n = 0;
  int stop_err = 0;
  initial begin
    forever begin
      logic [7:0] b;
      @(negedge tx_line);
      repeat (CLK_DIV / 2) @(negedge clk);
      if (tx_line !== 1'b0) stop_err++;
      for (int i = 0; i < 8; i++) begin
        repeat (CLK_DIV) @(negedge clk);
        b[i] = tx_line;
      end
      repeat (CLK_DIV) @(negedge clk);
      if (tx_line !== 1'b1) stop_err++;
      mon_q[mon_n] = b;
      mon_n++;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic burst_wr(input logic [7:0] base, input int n);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      addr = 1'b0; wdata = base + 8'(i); wr_en = 1'b1;
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic host_rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stop);
    @(negedge clk);
    rx_drv = 1'b0;
    wait_clk(CLK_DIV);
    for (int i = 0; i < 8; i++) begin
      rx_drv = b[i];
      wait_clk(CLK_DIV);
    end
    rx_drv = stop;
    wait_clk(CLK_DIV);
    rx_drv = 1'b1;
    wait_clk(CLK_DIV / 2);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int base;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);

    // R1 reset state
    chk("R1 tx_line", int'(tx_line), 1);
    chk("R1 irq", int'(irq), 0);
    host_rd(1'b1, v);
    chk("R1 status", int'(v), 'h80);

    // R2 frame format across walking patterns
    for (int k = 0; k < 8; k++) begin
      base = mon_n;
      host_wr(1'b0, 8'(1 << k) ^ 8'h5A);
      wait_clk(FRAME + 20);
      chk("R2 frame count", mon_n - base, 1);
      chk("R2 frame byte", int'(mon_q[base]), int'(8'(1 << k) ^ 8'h5A));
    end
    chk("R2 start/stop bits", stop_err, 0);

    // R3 + R5 stall mode burst
    overwrite_mode = 1'b0;
    base = mon_n;
    burst_wr(8'h30, DEPTH + 3);
    host_rd(1'b1, v);
    chk("R5 busy while full", int'(v[6]), 1);
    wait_clk(FRAME + 10);
    host_rd(1'b1, v);
    chk("R5 busy clears after dequeue", int'(v[6]), 0);
    wait_clk((DEPTH + 1) * FRAME);
    chk("R5 dropped writes count", mon_n - base, DEPTH + 1);
    for (int i = 0; i <= DEPTH; i++)
      chk("R3 stall order", int'(mon_q[base + i]), 'h30 + i);

    // R4 overwrite mode burst
    overwrite_mode = 1'b1;
    base = mon_n;
    burst_wr(8'h40, DEPTH + 3);
    host_rd(1'b1, v);
    chk("R4 no busy when full", int'(v[6]), 0);
    wait_clk((DEPTH + 2) * FRAME);
    chk("R4 count", mon_n - base, DEPTH + 1);
    for (int i = 0; i < DEPTH; i++)
      chk("R4 kept order", int'(mon_q[base + i]), 'h40 + i);
    chk("R4 newest replaced", int'(mon_q[base + DEPTH]), 'h40 + DEPTH + 2);
    overwrite_mode = 1'b0;

    // R6 + R7 hold and release
    hold = 1'b1;
    base = mon_n;
    host_rd(1'b1, v);
    chk("R6 free before first byte", int'(v[6]), 0);
    host_wr(1'b0, 8'h11);
    host_rd(1'b1, v);
    chk("R6 busy after held byte", int'(v[6]), 1);
    host_wr(1'b0, 8'h22);
    wait_clk(2 * FRAME);
    chk("R6 nothing sent", mon_n - base, 0);
    chk("R6 line idle", int'(tx_line), 1);
    hold = 1'b0;
    wait_clk(FRAME + 20);
    chk("R7 one byte sent", mon_n - base, 1);
    chk("R7 held byte is newest", int'(mon_q[base]), 'h22);
    host_rd(1'b1, v);
    chk("R7 busy cleared", int'(v[6]), 0);

    // R8 + R9 single receive
    send_rx(8'h3C, 1'b1);
    chk("R9 irq raised", int'(irq), 1);
    host_rd(1'b1, v);
    chk("R8 data waiting", int'(v[7]), 0);
    host_rd(1'b0, v);
    chk("R8 data value", int'(v), 'h3C);
    wait_clk(3);
    chk("R9 irq cleared", int'(irq), 0);
    host_rd(1'b1, v);
    chk("R8 empty after read", int'(v), 'h80);

    // R11 short glitch and bad stop bit
    @(negedge clk);
    rx_drv = 1'b0;
    wait_clk(3);
    rx_drv = 1'b1;
    wait_clk(FRAME + 40);
    chk("R11 glitch ignored", int'(irq), 0);
    send_rx(8'h55, 1'b0);
    wait_clk(FRAME);
    chk("R11 bad stop dropped irq", int'(irq), 0);
    host_rd(1'b1, v);
    chk("R11 bad stop status", int'(v), 'h80);

    // R10 overrun
    for (int i = 0; i <= DEPTH; i++) send_rx(8'h70 + 8'(i), 1'b1);
    host_rd(1'b1, v);
    chk("R10 overrun flag", int'(v[0]), 1);
    chk("R10 data waiting", int'(v[7]), 0);
    for (int i = 0; i < DEPTH; i++) begin
      host_rd(1'b0, v);
      chk("R10 stored bytes intact", int'(v), 'h70 + i);
    end
    host_rd(1'b1, v);
    chk("R10 flag cleared by status read", int'(v), 'h80);

    // R8 sweep of all byte values
    for (int val = 0; val < 256; val++) begin
      send_rx(8'(val), 1'b1);
      host_rd(1'b0, v);
      chk("R8 sweep", int'(v), val);
    end
    host_rd(1'b1, v);
    chk("R8 empty after sweep", int'(v), 'h80);

    done = 1;
    summary();
    $finish;
  end
endmodule